// File: doc/BRIEF.md
# Master Response Timeout Monitor

This block watches the command and response traffic of a single bus master and raises an interrupt when the master stops answering. A separate decoder asserts a busy indication while at least one transaction to or from the master is still waiting for an answer. It also pulses a response strobe whenever the master replies. Each cycle that is busy, has no response and has detection switched on counts as a stall. A run of consecutive stall cycles that reaches a programmable limit marks the master as hung.

The hung indication is a sticky interrupt. It stays high after the master recovers or the busy indication drops, until a recovery sequence pulses the clear input. The limit and the enable are static configuration supplied from outside the block. The limit is sampled on every cycle, and a limit of zero switches detection off.

Top module: `resp_timeout_mon`

## Requirements
- R1: While reset is applied and on the first cycle after it is released, `timed_out_irq_o` is 0.
- R2: With `det_en_i`=1 and `limit_i`=N (N>0), N consecutive cycles with `busy_i`=1 and `resp_i`=0 set `timed_out_irq_o` on the clock edge that ends the Nth such cycle. After N-1 such cycles it is still 0.
- R3: A cycle with `resp_i`=1 ends the stall run. The next stall cycle counts as the first of a new run.
- R4: A cycle with `busy_i`=0 ends the stall run.
- R5: A cycle with `det_en_i`=0 is never a stall cycle and ends the stall run. An interrupt that is already set stays set while the enable is low.
- R6: With `limit_i`=0, the interrupt never sets, however long the stall lasts.
- R7: Once set, `timed_out_irq_o` stays 1 until a cycle with `clr_i`=1 and no timeout event. That clear drops it on the following edge.
- R8: If `clr_i`=1 in a cycle where a timeout event occurs, the interrupt is 1 after that edge, whether it was previously set or not.
- R9: The stall count saturates at the limit and never wraps. A stall that continues past the limit keeps producing a timeout event on every cycle, even with the limit at the largest value the width allows.
- R10: `limit_i` is read live. Lowering it below the current stall run produces a timeout event on the next stall cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| det_en_i | input | 1 | Detection enable; low freezes and zeroes the stall count |
| limit_i | input | CW | Stall cycles allowed before a timeout; 0 disables |
| busy_i | input | 1 | At least one transaction is awaiting a response |
| resp_i | input | 1 | The master responded this cycle |
| clr_i | input | 1 | Clears the sticky interrupt |
| timed_out_irq_o | output | 1 | Sticky timed-out interrupt |

## Verification
Every result comes out of one register stage. An input pattern applied in a cycle shows up on `timed_out_irq_o` just after the edge that ends that cycle. The Nth stall cycle therefore raises the interrupt one edge after it is driven, and a clear lowers it one edge after it is driven. The bench drives inputs on the falling edge. A behavioural model, built on a run-length integer, updates on the rising edge. The output is compared with the model on every falling edge. Scenario checks read the output only after counting exactly which rising edges have consumed the driven stall cycles.

// File: rtl/resp_timeout_mon_pkg.sv
package resp_timeout_mon_pkg;

    localparam int unsigned DEF_CW = 16;

    // What the stall counter does in a cycle
    typedef enum logic [1:0] {
        CNT_ZERO = 2'd0,   // no stall or detection off: restart the run
        CNT_STEP = 2'd1,   // stall below the limit: advance
        CNT_SAT  = 2'd2    // stall at or past the limit: pin to the limit
    } cnt_act_e;

endpackage

// File: rtl/resp_timeout_stall_ctr.sv
module resp_timeout_stall_ctr
    import resp_timeout_mon_pkg::*;
#(
    parameter int unsigned CW = DEF_CW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          det_en_i,
    input  logic [CW-1:0] limit_i,
    input  logic          busy_i,
    input  logic          resp_i,
    output logic [CW-1:0] cnt_o,
    output logic          hit_o
);

    localparam int unsigned EW = CW + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } ctr_st_t;

    ctr_st_t  st_d, st_q;
    cnt_act_e act;
    logic     stall;
    logic     armed;
    logic     reached;
    logic [EW-1:0] next_ext;

    always_comb begin
        st_d     = st_q;
        stall    = det_en_i && busy_i && !resp_i;
        armed    = (limit_i != '0);
        next_ext = {1'b0, st_q.cnt} + EW'(1);
        reached  = (next_ext >= {1'b0, limit_i});

        if (!stall || !armed) begin
            act = CNT_ZERO;
        end else if (reached) begin
            act = CNT_SAT;
        end else begin
            act = CNT_STEP;
        end

        unique case (act)
            CNT_ZERO: st_d.cnt = '0;
            CNT_STEP: st_d.cnt = next_ext[CW-1:0];
            CNT_SAT:  st_d.cnt = limit_i;
            default:  st_d.cnt = '0;
        endcase

        hit_o = stall && armed && reached;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;

endmodule

// File: rtl/resp_timeout_sticky.sv
module resp_timeout_sticky (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
    } stk_st_t;

    stk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i) begin
            st_d.flag = 1'b1;   // a new event outranks a clear
        end else if (clr_i) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/resp_timeout_mon.sv
module resp_timeout_mon
    import resp_timeout_mon_pkg::*;
#(
    parameter int unsigned CW = DEF_CW
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          det_en_i,
    input  logic [CW-1:0] limit_i,
    input  logic          busy_i,
    input  logic          resp_i,
    input  logic          clr_i,
    output logic          timed_out_irq_o
);

    logic [CW-1:0] cnt_w;
    logic          hit_w;

    resp_timeout_stall_ctr #(
        .CW(CW)
    ) u_ctr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .det_en_i (det_en_i),
        .limit_i  (limit_i),
        .busy_i   (busy_i),
        .resp_i   (resp_i),
        .cnt_o    (cnt_w),
        .hit_o    (hit_w)
    );

    resp_timeout_sticky u_irq (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .set_i  (hit_w),
        .clr_i  (clr_i),
        .flag_o (timed_out_irq_o)
    );

endmodule

// File: rtl/resp_timeout_mon_chk.sv
module resp_timeout_mon_chk #(
    parameter int unsigned CW = 16
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          det_en_i,
    input logic [CW-1:0] limit_i,
    input logic          busy_i,
    input logic          resp_i,
    input logic          clr_i,
    input logic [CW-1:0] cnt,
    input logic          hit,
    input logic          irq
);

    // R2: the interrupt only rises after an enabled stall cycle
    a_r2_rise_from_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq) |-> $past(det_en_i && busy_i && !resp_i && (limit_i != '0)));

    // R3: a response restarts the run
    a_r3_resp_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resp_i |=> (cnt == '0));

    // R4: an idle cycle restarts the run
    a_r4_idle_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_i |=> (cnt == '0));

    // R5: with detection off, a clear interrupt stays clear and the run is zeroed
    a_r5_off_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!det_en_i && !irq) |=> (!irq && (cnt == '0)));

    // R6: a zero limit never raises the interrupt
    a_r6_zero_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((limit_i == '0) && !irq) |=> !irq);

    // R7: sticky without a clear
    a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq && !clr_i) |=> irq);

    // R7: a clear with no event drops it
    a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_i && !hit) |=> !irq);

    // R8: an event always leaves the interrupt set
    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit |=> irq);

    // R9: an ongoing enabled stall never wraps the count to zero
    a_r9_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cnt != '0) && det_en_i && busy_i && !resp_i && (limit_i != '0)) |=> (cnt != '0));

endmodule

bind resp_timeout_mon resp_timeout_mon_chk #(
    .CW(CW)
) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .det_en_i (det_en_i),
    .limit_i  (limit_i),
    .busy_i   (busy_i),
    .resp_i   (resp_i),
    .clr_i    (clr_i),
    .cnt      (cnt_w),
    .hit      (hit_w),
    .irq      (timed_out_irq_o)
);

// File: tb/tb_resp_timeout_mon.sv
`timescale 1ns/1ps
module tb_resp_timeout_mon;

    localparam int unsigned CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          en = 1'b1;
    logic [CW-1:0] lim = '0;
    logic          busy = 1'b0;
    logic          resp = 1'b0;
    logic          clr = 1'b0;
    logic          irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string phase = "R1 reset";

    // behavioural reference
    int run = 0;
    bit m_irq = 1'b0;

    always #2 clk = ~clk;

    resp_timeout_mon #(.CW(CW)) dut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .det_en_i        (en),
        .limit_i         (lim),
        .busy_i          (busy),
        .resp_i          (resp),
        .clr_i           (clr),
        .timed_out_irq_o (irq)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            run   = 0;
            m_irq = 1'b0;
        end else begin
            bit stalled;
            bit fire;
            stalled = en && busy && !resp;
            run     = stalled ? run + 1 : 0;
            fire    = stalled && (lim != 0) && (run >= int'(lim));
            m_irq   = fire || (m_irq && !clr);
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (irq !== m_irq) begin
                fails++;
                $display("FAIL %s: model compare irq=%b expected %b at %0t", phase, irq, m_irq, $time);
            end
        end
    end

    task automatic tick(input bit e, input logic [CW-1:0] l, input bit b, input bit r, input bit c);
        @(negedge clk);
        en = e; lim = l; busy = b; resp = r; clr = c;
    endtask

    task automatic peek(input bit exp, input string tag);
        checks++;
        if (irq !== exp) begin
            fails++;
            $display("FAIL %s: irq=%b expected %b at %0t", tag, irq, exp, $time);
        end
    endtask

    task automatic clear_all(input logic [CW-1:0] l);
        tick(1, l, 0, 0, 1);
        tick(1, l, 0, 0, 0);
        peek(0, "R7 clear after scenario");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        peek(0, "R1 during reset");
        rst_n = 1'b1;
        @(negedge clk);
        peek(0, "R1 after release");

        phase = "R2 threshold";
        repeat (4) tick(1, 4, 1, 0, 0);
        peek(0, "R2 not after N-1");
        tick(1, 4, 0, 0, 0);
        peek(1, "R2 set after N");

        phase = "R7 sticky";
        repeat (3) tick(1, 4, 0, 0, 0);
        peek(1, "R7 held without clear");
        tick(1, 4, 0, 0, 1);
        tick(1, 4, 0, 0, 0);
        peek(0, "R7 cleared");

        phase = "R3 response";
        repeat (3) tick(1, 4, 1, 0, 0);
        tick(1, 4, 1, 1, 0);
        repeat (3) tick(1, 4, 1, 0, 0);
        tick(1, 4, 0, 0, 0);
        peek(0, "R3 response restarts run");
        repeat (4) tick(1, 4, 1, 0, 0);
        tick(1, 4, 0, 0, 0);
        peek(1, "R3 full run after response");
        clear_all(4);

        phase = "R4 idle";
        repeat (3) tick(1, 4, 1, 0, 0);
        tick(1, 4, 0, 0, 0);
        repeat (3) tick(1, 4, 1, 0, 0);
        tick(1, 4, 0, 0, 0);
        peek(0, "R4 idle restarts run");

        phase = "R5 enable";
        repeat (10) tick(0, 4, 1, 0, 0);
        tick(1, 4, 0, 0, 0);
        peek(0, "R5 disabled stall ignored");
        repeat (3) tick(1, 4, 1, 0, 0);
        tick(0, 4, 1, 0, 0);
        repeat (3) tick(1, 4, 1, 0, 0);
        tick(1, 4, 0, 0, 0);
        peek(0, "R5 enable drop restarts run");
        repeat (4) tick(1, 4, 1, 0, 0);
        repeat (5) tick(0, 4, 1, 0, 0);
        peek(1, "R5 set flag kept with enable low");
        clear_all(4);

        phase = "R6 zero limit";
        repeat (20) tick(1, 0, 1, 0, 0);
        tick(1, 0, 0, 0, 0);
        peek(0, "R6 zero limit never fires");

        phase = "R8 set wins";
        repeat (2) tick(1, 2, 1, 0, 1);
        tick(1, 2, 0, 0, 0);
        peek(1, "R8 first event with clear");
        clear_all(2);
        repeat (2) tick(1, 2, 1, 0, 0);
        tick(1, 2, 1, 0, 1);
        tick(1, 2, 1, 0, 1);
        peek(1, "R8 set flag with clear and event");
        tick(1, 2, 0, 0, 0);
        peek(1, "R8 event beats clear");
        clear_all(2);

        phase = "R10 live limit";
        repeat (5) tick(1, 10, 1, 0, 0);
        tick(1, 3, 1, 0, 0);
        peek(0, "R10 below old limit");
        tick(1, 3, 0, 0, 0);
        peek(1, "R10 lowered limit fires");
        clear_all(3);

        phase = "R9 saturation";
        repeat (65535) tick(1, 16'hFFFF, 1, 0, 0);
        repeat (11) tick(1, 16'hFFFF, 1, 0, 1);
        tick(1, 16'hFFFF, 0, 0, 0);
        peek(1, "R9 saturated run keeps firing");
        clear_all(16'hFFFF);

        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: run did not finish, phase %s", phase);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule